// File: doc/BRIEF.md
# Relative Branch Condition Unit

This block resolves the conditional relative branches of a classic 8-bit CPU. Each cycle that a request is presented, it picks one processor status bit (N, V, C or Z) with a 3-bit condition selector. It then tests that bit against the polarity the selector asks for, and the outcome is the taken decision. It also forms the branch target by adding the sign-extended 8-bit displacement to the address of the instruction that follows the branch.

The result is registered. One clock after a valid request, the unit reports whether the branch is taken and the program counter value that fetch should use next. When the branch is not taken, that value is the next-instruction address unchanged. A page-cross indication flags a taken target whose high byte differs from that of the next-instruction address, so that surrounding sequencing can add a penalty cycle. The unit only reads the status bits and never changes them.

Top module: `rel_branch_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, `out_valid`, `taken` and `page_cross` are 0 and `pc_out` is 0x0000.
- R2: `out_valid` equals the `in_valid` value of the previous clock edge.
- R3: `cond_sel[2:1]` chooses the tested bit: 00 selects N, 01 selects V, 10 selects C and 11 selects Z. `cond_sel[0]` gives the required value of that bit. The branch is taken exactly when the chosen bit equals `cond_sel[0]`, so 100 is carry-clear and 111 is zero-set.
- R4: For a taken branch, `pc_out` equals `next_pc` plus `offset` read as a two's-complement byte and sign-extended to 16 bits, modulo 2^16.
- R5: For a branch that is not taken, `pc_out` equals the `next_pc` that was presented.
- R6: `page_cross` is 1 exactly when the branch is taken and `pc_out[15:8]` differs from the presented `next_pc[15:8]`.
- R7: The displacement extremes 0x7F (+127) and 0x80 (-128) give the correct target, including when the sum wraps past 0xFFFF or below 0x0000.
- R8: A cycle with `in_valid` low leaves `taken`, `pc_out` and `page_cross` at their previous values.
- R9: Status bits that the selector does not choose have no effect on `taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A branch request is present this cycle |
| cond_sel | input | 3 | Condition selector: bits 2:1 choose the flag, bit 0 gives the required value |
| flag_n | input | 1 | Negative status bit |
| flag_v | input | 1 | Overflow status bit |
| flag_z | input | 1 | Zero status bit |
| flag_c | input | 1 | Carry status bit |
| next_pc | input | 16 | Address of the instruction after the branch |
| offset | input | 8 | Signed branch displacement |
| out_valid | output | 1 | Result registers hold a new result |
| taken | output | 1 | The branch condition was met |
| pc_out | output | 16 | Next program counter value |
| page_cross | output | 1 | A taken target lies in a different 256-byte page |

## Verification
All four results are due exactly one clock edge after the request that produced them. The bench drives inputs on the falling edge and compares the outputs on the following falling edge, before it drives the next request. A behavioural reference model holds the expected values. It updates them only when a valid request is driven, so idle cycles must show that the held values stay unchanged. Directed vectors cover every selector code with the chosen flag both set and clear, changes to unchosen flags, the displacement extremes, and wraparound in both directions. Random requests follow.

// File: rtl/rel_branch_pkg.sv
// Package rel_branch_pkg
// Holds the shared types for the relative branch unit: the encoding that
// selects a flag and the bundle of status bits.
// Assumes the selector layout used by the classic branch opcodes: the two
// upper bits pick the flag, and the low bit gives the required value.
package rel_branch_pkg;

    typedef enum logic [1:0] {
        SEL_NEG  = 2'b00,
        SEL_OVF  = 2'b01,
        SEL_CRY  = 2'b10,
        SEL_ZERO = 2'b11
    } flag_pick_e;

    typedef struct packed {
        logic neg;
        logic ovf;
        logic zero;
        logic cry;
    } status_bits_t;

endpackage

// File: rtl/branch_cond_eval.sv
// Module branch_cond_eval
// Combinational test of one branch condition. It picks the status bit named
// by sel[2:1] and reports a match when that bit equals sel[0].
// Assumes: the selector is always one of the eight defined codes (all are
// legal), and the status bits are stable for the cycle.
module branch_cond_eval
    import rel_branch_pkg::*;
(
    input  logic [2:0]   sel,
    input  status_bits_t flags,
    output logic         cond_met
);

    flag_pick_e pick;
    logic       chosen_bit;

    // Decode the flag field of the selector.
    always_comb begin
        pick = flag_pick_e'(sel[2:1]);
    end

    // Route the chosen status bit out.
    always_comb begin
        unique case (pick)
            SEL_NEG:  chosen_bit = flags.neg;
            SEL_OVF:  chosen_bit = flags.ovf;
            SEL_CRY:  chosen_bit = flags.cry;
            SEL_ZERO: chosen_bit = flags.zero;
            default:  chosen_bit = 1'b0;
        endcase
    end

    // Compare the chosen bit with the required polarity.
    always_comb begin
        cond_met = (chosen_bit == sel[0]);
    end

endmodule

// File: rtl/branch_target_calc.sv
// Module branch_target_calc
// Combinational target arithmetic. It sign-extends the displacement to the
// address width, adds it to the next-instruction address modulo 2^PC_W, and
// flags a page change when the upper PAGE_BITS of the sum and of the base
// differ.
// Assumes: OFF_W < PC_W and PAGE_BITS <= PC_W.
module branch_target_calc #(
    parameter int PC_W      = 16,
    parameter int OFF_W     = 8,
    parameter int PAGE_BITS = 8
) (
    input  logic [PC_W-1:0]  base_pc,
    input  logic [OFF_W-1:0] disp,
    output logic [PC_W-1:0]  target,
    output logic             new_page
);

    localparam int EXT_W = PC_W - OFF_W;
    localparam int PG_LO = PC_W - PAGE_BITS;

    logic [PC_W-1:0] disp_ext;

    // Replicate the displacement sign bit up to the address width.
    always_comb begin
        disp_ext = {{EXT_W{disp[OFF_W-1]}}, disp};
    end

    // Add with natural wraparound at the address width.
    always_comb begin
        target = base_pc + disp_ext;
    end

    // Compare the page fields of the base and the sum.
    always_comb begin
        new_page = (target[PC_W-1:PG_LO] != base_pc[PC_W-1:PG_LO]);
    end

endmodule

// File: rtl/rel_branch_unit.sv
// Module rel_branch_unit (top)
// Resolves a conditional relative branch. The result is registered, so it
// appears one clock after the request. On a taken branch, pc_out is the
// displaced target. Otherwise pc_out is next_pc. page_cross marks a taken
// target that lies outside the page of next_pc. Without a request, the
// result registers hold their values.
// Assumes: synchronous active-low reset; the inputs are sampled on the
// rising edge only when in_valid is high. Status bits are only read.
module rel_branch_unit
    import rel_branch_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int OFF_W     = 8,
    parameter int PAGE_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       cond_sel,
    input  logic             flag_n,
    input  logic             flag_v,
    input  logic             flag_z,
    input  logic             flag_c,
    input  logic [PC_W-1:0]  next_pc,
    input  logic [OFF_W-1:0] offset,
    output logic             out_valid,
    output logic             taken,
    output logic [PC_W-1:0]  pc_out,
    output logic             page_cross
);

    status_bits_t    flags;
    logic            cond_met;
    logic [PC_W-1:0] target;
    logic            new_page;

    // Gather the status inputs into one bundle.
    always_comb begin
        flags = '{neg: flag_n, ovf: flag_v, zero: flag_z, cry: flag_c};
    end

    branch_cond_eval u_cond (
        .sel      (cond_sel),
        .flags    (flags),
        .cond_met (cond_met)
    );

    branch_target_calc #(
        .PC_W      (PC_W),
        .OFF_W     (OFF_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_target (
        .base_pc  (next_pc),
        .disp     (offset),
        .target   (target),
        .new_page (new_page)
    );

    // Track whether the result registers were loaded on the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Load the decision, the next PC and the page flag for a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken      <= 1'b0;
            pc_out     <= '0;
            page_cross <= 1'b0;
        end else if (in_valid) begin
            taken      <= cond_met;
            pc_out     <= cond_met ? target : next_pc;
            page_cross <= cond_met & new_page;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5
    not_taken_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || pc_out == $past(next_pc)));

    // R4
    taken_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!taken ||
            (pc_out - $past(next_pc)) ==
            {{(PC_W-OFF_W){$past(offset[OFF_W-1])}}, $past(offset)}));

    // R6
    no_cross_when_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> !page_cross);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pc_out) && $stable(taken) && $stable(page_cross)));

endmodule

// File: tb/tb_rel_branch_unit.sv
module tb_rel_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  cond_sel;
    logic        flag_n, flag_v, flag_z, flag_c;
    logic [15:0] next_pc;
    logic [7:0]  offset;
    logic        out_valid, taken, page_cross;
    logic [15:0] pc_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Expected outputs from the reference model.
    bit  e_valid, e_taken, e_page;
    int  e_pc;
    string pend_tag = "R1";

    always #4 clk = ~clk;

    rel_branch_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_sel(cond_sel),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .next_pc(next_pc), .offset(offset), .out_valid(out_valid),
        .taken(taken), .pc_out(pc_out), .page_cross(page_cross)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check({pend_tag, " R2 out_valid"}, int'(out_valid), int'(e_valid));
        check({pend_tag, " R3 taken"}, int'(taken), int'(e_taken));
        check({pend_tag, (e_taken ? " R4 pc_out" : " R5 pc_out")}, int'(pc_out), e_pc);
        check({pend_tag, " R6 page_cross"}, int'(page_cross), int'(e_page));
    endtask

    // One request (or idle cycle): check the last result, then drive anew.
    task automatic apply(input bit v, input bit [2:0] s, input bit [3:0] nvzc,
                         input int npc, input int off, input string tag);
        bit fl;
        int sd, tgt;
        @(negedge clk);
        compare_all();
        in_valid = v; cond_sel = s;
        {flag_n, flag_v, flag_z, flag_c} = nvzc;
        next_pc = npc[15:0]; offset = off[7:0];
        pend_tag = tag;
        e_valid = v;
        if (v) begin
            case (s[2:1])
                2'd0: fl = nvzc[3];
                2'd1: fl = nvzc[2];
                2'd2: fl = nvzc[0];
                default: fl = nvzc[1];
            endcase
            e_taken = (fl == s[0]);
            sd  = (off[7:0] >= 128) ? int'(off[7:0]) - 256 : int'(off[7:0]);
            tgt = (npc + sd + 65536) % 65536;
            e_pc   = e_taken ? tgt : (npc & 16'hFFFF);
            e_page = e_taken && ((tgt / 256) != ((npc & 16'hFFFF) / 256));
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; cond_sel = 3'b111;
        {flag_n, flag_v, flag_z, flag_c} = 4'hF;
        next_pc = 16'h1234; offset = 8'h10;
        e_valid = 0; e_taken = 0; e_page = 0; e_pc = 0;
        repeat (3) @(negedge clk);
        // R1: reset state with a request held on the inputs
        compare_all();
        rst_n = 1'b1; in_valid = 1'b0;
        // R3: every selector code with its flag set and clear
        for (int s = 0; s < 8; s++) begin
            apply(1, 3'(s), 4'hF, 16'h2040, 8'h05, "R3_set");
            apply(1, 3'(s), 4'h0, 16'h2040, 8'h05, "R3_clr");
        end
        // R9: unchosen flags toggled around a fixed chosen flag
        for (int p = 0; p < 16; p++) begin
            apply(1, 3'b110, 4'(p) & 4'b1101, 16'h3000, 8'h02, "R9_zclr");
            apply(1, 3'b001, 4'(p) | 4'b1000, 16'h3000, 8'h02, "R9_nset");
        end
        // R7: displacement extremes and wraparound
        apply(1, 3'b101, 4'b0001, 16'h4000, 8'h7F, "R7_plus127");
        apply(1, 3'b101, 4'b0001, 16'h4000, 8'h80, "R7_minus128");
        apply(1, 3'b101, 4'b0001, 16'hFFF0, 8'h7F, "R7_wrap_up");
        apply(1, 3'b101, 4'b0001, 16'h0005, 8'h80, "R7_wrap_down");
        // R6: page crossing forward, backward, and not taken
        apply(1, 3'b100, 4'b0000, 16'h10F0, 8'h20, "R6_fwd");
        apply(1, 3'b100, 4'b0000, 16'h1010, 8'hE0, "R6_back");
        apply(1, 3'b100, 4'b0001, 16'h10F0, 8'h20, "R6_fall");
        apply(1, 3'b100, 4'b0000, 16'h1000, 8'h7F, "R6_same");
        // R8: idle cycles with changed inputs must keep the result
        apply(0, 3'b011, 4'b0000, 16'hBEEF, 8'h33, "R8_idle");
        apply(0, 3'b000, 4'b1111, 16'h0000, 8'h80, "R8_idle");
        // R4 / R5: random requests mixed with idles
        for (int i = 0; i < 300; i++) begin
            apply(($urandom % 5) != 0, 3'($urandom), 4'($urandom),
                  int'($urandom % 65536), int'($urandom % 256), "R4R5_rand");
        end
        apply(0, 3'b000, 4'b0000, 16'h0000, 8'h00, "R8_flush");
        @(negedge clk);
        compare_all();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule